// File: doc/BRIEF.md
# Pulse-Position Reader Frame Decoder

This block sits behind a chip-rate sampler on the reader-to-card path of a contactless link. Each tick with `chip_valid` high brings one sampled chip, where 1 means the carrier was modulated and 0 means it was not. At the nominal 9.44 µs chip period, a data symbol lasts eight chips (75.52 µs). Each symbol carries two bits as the position of a single unmodulated chip among four odd chip slots.

While idle, the decoder watches a sliding eight-chip window for the start marker. It then slices the stream into symbol slots and turns each slot into a bit pair. Four pairs make one byte, packed from bit 0 upward. A frame closes when the four-chip end marker appears at the head of a slot. Every byte comes out as a one-cycle strobe with its data. A clean close gives a one-cycle frame-done pulse. A malformed symbol, or a close with a part-built byte, gives a one-cycle error pulse, and the decoder goes back to hunting for a start marker.

Top module: `ppm_frame_decoder`

## Requirements
- R1: While `rst_n` is low, and until a frame event occurs, `byte_valid`, `frame_done` and `frame_err` are low.
- R2: In the hunting state, a frame starts when the last eight accepted chips are 0,1,1,1,1,0,1,1 in arrival order. Chips before that pattern produce no output.
- R3: In a frame, an eight-chip slot that is all ones except for a single 0 at chip index 2p+1 (p = 0..3, index counted from 0 at the first chip of the slot) decodes to a pair whose lower bit is p[1] and whose upper bit is p[0].
- R4: Pairs fill a byte from bits [1:0] up to bits [7:6]. `byte_valid` is high for exactly one cycle, the cycle after the chip that completes the fourth pair, and `byte_data` then holds the byte. For example, the stream for 0xE1 yields 0xE1.
- R5: If the first four chips of a slot are 1,1,0,1 and no pair of a byte is pending, `frame_done` pulses for one cycle after the fourth chip, and the block returns to hunting.
- R6: If the end marker arrives while one to three pairs of a byte are pending, `frame_err` pulses instead, and that byte is never emitted.
- R7: An eight-chip slot that matches no valid symbol pulses `frame_err`. The chips that follow are ignored until a new start marker.
- R8: Ticks with `chip_valid` low change nothing: no pulse in the next cycle, and `byte_data` is held.
- R9: At most one of `byte_valid`, `frame_done` and `frame_err` is high in any cycle.
- R10: After a frame ends or fails, a new frame needs eight fresh chips that form the start marker. Chips seen before the end do not count toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_valid | input | 1 | A sampled chip is present this cycle |
| chip_in | input | 1 | Chip value, 1 = modulation present |
| byte_valid | output | 1 | One-cycle strobe for a decoded byte |
| byte_data | output | 8 | Last decoded byte |
| frame_done | output | 1 | One-cycle pulse on a clean frame end |
| frame_err | output | 1 | One-cycle pulse on a bad symbol or a broken frame end |

## Verification
Each of the four symbol positions appears in directed and in random bytes. This separates a correct pair orientation from a swapped one, and a correct byte fill order from a reversed one. The bench varies frames from empty to several bytes, with random idle gaps between chips. These cases tell a clean end apart from an end with one to three pairs pending, and show that idle ticks are ignored. Corrupt slots, including one equal to the start pattern, check that errors abort the frame and that stale chips cannot restart it. A lone start marker followed by the end marker checks that an empty frame still closes cleanly.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  localparam int SYM_CHIPS      = 8;
  localparam int END_CHIPS      = 4;
  localparam int PAIR_BITS      = 2;
  localparam int BYTE_BITS      = 8;
  localparam int PAIRS_PER_BYTE = BYTE_BITS / PAIR_BITS;
  localparam int POSITIONS      = 1 << PAIR_BITS;

  localparam logic [SYM_CHIPS-1:0] START_PAT = 8'b0111_1011;
  localparam logic [END_CHIPS-1:0] END_PAT   = 4'b1101;

  typedef enum logic [0:0] {ST_HUNT = 1'b0, ST_DATA = 1'b1} dec_state_e;

  typedef struct packed {
    logic                 ok;
    logic [PAIR_BITS-1:0] pair;
  } sym_dec_t;

  // Chip 0 of a slot is the MSB of the vector. The unmodulated chip of
  // position p sits at chip index 2p+1. The pair is {p[0], p[1]} as {hi, lo}.
  function automatic sym_dec_t decode_sym(input logic [SYM_CHIPS-1:0] s);
    sym_dec_t r;
    r.ok   = 1'b0;
    r.pair = '0;
    for (int p = 0; p < POSITIONS; p++) begin
      logic [SYM_CHIPS-1:0] ref_sym;
      ref_sym = '1;
      ref_sym[SYM_CHIPS-2-2*p] = 1'b0;
      if (s == ref_sym) begin
        r.ok      = 1'b1;
        r.pair[1] = p[0];
        r.pair[0] = p[1];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ppm_start_hunter.sv
module ppm_start_hunter
  import ppm_pkg::*;
#(
  parameter int                  WIN     = SYM_CHIPS,
  parameter logic [WIN-1:0]      PATTERN = START_PAT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic chip,
  input  logic clear,
  output logic hit
);

  logic [WIN-1:0] win_q, win_d, win_shift;

  assign win_shift = {win_q[WIN-2:0], chip};

  always_comb begin
    win_d = win_q;
    if (clear)         win_d = '1;
    else if (shift_en) win_d = win_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '1;
    else        win_q <= win_d;
  end

  assign hit = shift_en && !clear && (win_shift == PATTERN);

endmodule

// File: rtl/ppm_slot_slicer.sv
module ppm_slot_slicer
  import ppm_pkg::*;
#(
  parameter int                   N_CHIPS = SYM_CHIPS,
  parameter int                   N_END   = END_CHIPS,
  parameter logic [N_END-1:0]     END_SEQ = END_PAT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chip_en,
  input  logic               chip,
  input  logic               restart,
  output logic               end_seen,
  output logic               full_seen,
  output logic [N_CHIPS-1:0] full_sym
);

  localparam int CW = $clog2(N_CHIPS);
  localparam logic [CW-1:0] LAST_IDX = CW'(N_CHIPS - 1);
  localparam logic [CW-1:0] END_IDX  = CW'(N_END - 1);

  logic [N_CHIPS-1:0] sym_q, sym_d;
  logic [CW-1:0]      cnt_q, cnt_d;

  assign full_sym  = {sym_q[N_CHIPS-2:0], chip};
  assign end_seen  = chip_en && (cnt_q == END_IDX) &&
                     (full_sym[N_END-1:0] == END_SEQ);
  assign full_seen = chip_en && (cnt_q == LAST_IDX);

  always_comb begin
    sym_d = sym_q;
    cnt_d = cnt_q;
    if (restart) begin
      sym_d = '1;
      cnt_d = '0;
    end else if (chip_en) begin
      sym_d = full_sym;
      cnt_d = (cnt_q == LAST_IDX || end_seen) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= '1;
      cnt_q <= '0;
    end else begin
      sym_q <= sym_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ppm_pair_packer.sv
module ppm_pair_packer
  import ppm_pkg::*;
#(
  parameter int PW    = PAIR_BITS,
  parameter int BW    = BYTE_BITS,
  localparam int NP   = BW / PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          pair_en,
  input  logic [PW-1:0] pair,
  output logic          pending,
  output logic          byte_done,
  output logic [BW-1:0] byte_next
);

  localparam int CW = (NP > 1) ? $clog2(NP) : 1;
  localparam logic [CW-1:0] LAST_PAIR = CW'(NP - 1);

  logic [BW-1:0] acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign byte_next = {pair, acc_q[BW-1:PW]};
  assign byte_done = pair_en && !clear && (cnt_q == LAST_PAIR);
  assign pending   = (cnt_q != '0);

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clear) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (pair_en) begin
      acc_d = byte_next;
      cnt_d = (cnt_q == LAST_PAIR) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ppm_frame_decoder.sv
module ppm_frame_decoder
  import ppm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chip_valid,
  input  logic                 chip_in,
  output logic                 byte_valid,
  output logic [BYTE_BITS-1:0] byte_data,
  output logic                 frame_done,
  output logic                 frame_err
);

  dec_state_e state_q, state_d;

  logic hunt_shift, hunt_clear, start_hit;
  logic slot_en, slot_restart, end_seen, full_seen;
  logic [SYM_CHIPS-1:0] full_sym;
  sym_dec_t dec;
  logic pack_clear, pair_en, pending, byte_done;
  logic [BYTE_BITS-1:0] byte_next;

  logic                 bv_d, done_d, err_d;
  logic [BYTE_BITS-1:0] bd_d;

  assign hunt_shift = (state_q == ST_HUNT) && chip_valid;
  assign slot_en    = (state_q == ST_DATA) && chip_valid;
  assign dec        = decode_sym(full_sym);

  ppm_start_hunter u_hunter (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (hunt_shift),
    .chip     (chip_in),
    .clear    (hunt_clear),
    .hit      (start_hit)
  );

  ppm_slot_slicer u_slicer (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (slot_en),
    .chip      (chip_in),
    .restart   (slot_restart),
    .end_seen  (end_seen),
    .full_seen (full_seen),
    .full_sym  (full_sym)
  );

  ppm_pair_packer u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (pack_clear),
    .pair_en   (pair_en),
    .pair      (dec.pair),
    .pending   (pending),
    .byte_done (byte_done),
    .byte_next (byte_next)
  );

  always_comb begin
    state_d      = state_q;
    hunt_clear   = 1'b0;
    slot_restart = 1'b0;
    pack_clear   = 1'b0;
    pair_en      = 1'b0;
    bv_d         = 1'b0;
    done_d       = 1'b0;
    err_d        = 1'b0;
    bd_d         = byte_data;
    unique case (state_q)
      ST_HUNT: begin
        if (start_hit) begin
          state_d      = ST_DATA;
          slot_restart = 1'b1;
          pack_clear   = 1'b1;
        end
      end
      ST_DATA: begin
        if (end_seen) begin
          state_d      = ST_HUNT;
          hunt_clear   = 1'b1;
          slot_restart = 1'b1;
          pack_clear   = 1'b1;
          done_d       = !pending;
          err_d        = pending;
        end else if (full_seen) begin
          if (dec.ok) begin
            pair_en = 1'b1;
            if (byte_done) begin
              bv_d = 1'b1;
              bd_d = byte_next;
            end
          end else begin
            state_d      = ST_HUNT;
            hunt_clear   = 1'b1;
            slot_restart = 1'b1;
            pack_clear   = 1'b1;
            err_d        = 1'b1;
          end
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      state_q    <= state_d;
      byte_valid <= bv_d;
      byte_data  <= bd_d;
      frame_done <= done_d;
      frame_err  <= err_d;
    end
  end

endmodule

// File: rtl/ppm_frame_decoder_chk.sv
module ppm_frame_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chip_valid,
  input logic       chip_in,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       frame_done,
  input logic       frame_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!byte_valid && !frame_done && !frame_err)
        else $error("R1: output pulse during reset");
    end
  end

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_valid, frame_done, frame_err}));

  assert_idle_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |=> !(byte_valid || frame_done || frame_err));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |=> $stable(byte_data));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_end_last_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && !chip_in) |=> !frame_done);

endmodule

bind ppm_frame_decoder ppm_frame_decoder_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_valid (chip_valid),
  .chip_in    (chip_in),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .frame_done (frame_done),
  .frame_err  (frame_err)
);

// File: tb/ppm_frame_decoder_tb_top.sv
module ppm_frame_decoder_tb_top;

  logic       clk;
  logic       rst_n;
  logic       chip_valid;
  logic       chip_in;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       frame_done;
  logic       frame_err;

  int n_checks = 0;
  int n_bad    = 0;
  int n_done   = 0;
  int n_err    = 0;
  bit finished = 0;

  bit         chips[$];
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  ppm_frame_decoder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_valid (chip_valid),
    .chip_in    (chip_in),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .frame_done (frame_done),
    .frame_err  (frame_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) got_q.push_back(byte_data);
      if (frame_done) n_done++;
      if (frame_err)  n_err++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side encoder: position p has its 0 chip at index 2p+1,
  // pair lo = p[1], hi = p[0], so p = 2*lo + hi.
  task automatic add_sym(input int p);
    for (int k = 0; k < 8; k++) chips.push_back(k == 2*p+1 ? 1'b0 : 1'b1);
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 4; i++) add_sym(2*int'(b[2*i]) + int'(b[2*i+1]));
  endtask

  task automatic add_pairs(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) add_sym(2*int'(b[2*i]) + int'(b[2*i+1]));
  endtask

  task automatic add_start();
    bit pat[8] = '{0,1,1,1,1,0,1,1};
    for (int k = 0; k < 8; k++) chips.push_back(pat[k]);
  endtask

  task automatic add_end();
    bit pat[4] = '{1,1,0,1};
    for (int k = 0; k < 4; k++) chips.push_back(pat[k]);
  endtask

  task automatic add_idle(input int n);
    for (int k = 0; k < n; k++) chips.push_back(1'b1);
  endtask

  task automatic play(input bit gaps);
    while (chips.size() > 0) begin
      @(negedge clk);
      chip_valid = 1'b1;
      chip_in    = chips.pop_front();
      @(negedge clk);
      chip_valid = 1'b0;
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input string req, input int exp_done, input int exp_err);
    check(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {req, " byte value"}, got_q[i], exp_q[i]);
    check(n_done == exp_done, {req, " frame_done count"}, n_done, exp_done);
    check(n_err == exp_err, {req, " frame_err count"}, n_err, exp_err);
    got_q.delete();
    exp_q.delete();
    n_done = 0;
    n_err  = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2417));
    rst_n      = 1'b0;
    chip_valid = 1'b0;
    chip_in    = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet in reset
    check(!byte_valid && !frame_done && !frame_err, "R1 reset outputs", {byte_valid, frame_done, frame_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!byte_valid && !frame_done && !frame_err, "R1 after release", {byte_valid, frame_done, frame_err}, 0);

    // R4 R3: directed 0xE1 with no gaps
    add_idle(5); add_start(); add_byte(8'hE1); add_end();
    exp_q.push_back(8'hE1);
    play(0);
    verify("R4 R3 byte E1", 1, 0);

    // R3: one byte per symbol position (0x00, 0x55, 0xAA, 0xFF)
    add_start(); add_byte(8'h00); add_byte(8'h55); add_byte(8'hAA); add_byte(8'hFF); add_end();
    exp_q.push_back(8'h00); exp_q.push_back(8'h55); exp_q.push_back(8'hAA); exp_q.push_back(8'hFF);
    play(1);
    verify("R3 all positions", 1, 0);

    // R5: empty frame
    add_idle(3); add_start(); add_end();
    play(1);
    verify("R5 empty frame", 1, 0);

    // R2: data symbols before any start marker are ignored
    add_byte(8'h3C); add_byte(8'hC3); add_end();
    play(1);
    verify("R2 no start", 0, 0);

    // R6: partial bytes, 1..3 pairs pending
    for (int n = 1; n <= 3; n++) begin
      add_start(); add_byte(8'h5A); add_pairs(8'h96, n); add_end(); add_idle(2);
      exp_q.push_back(8'h5A);
      play(1);
      verify("R6 partial byte", 0, 1);
    end

    // R7: corrupt symbol aborts; later chips ignored
    add_start(); add_byte(8'h11);
    for (int k = 0; k < 8; k++) chips.push_back(1'b0);
    add_byte(8'h22); add_end();
    exp_q.push_back(8'h11);
    play(1);
    verify("R7 bad symbol", 0, 1);

    // R10: slot equal to start pattern is an error, and not a new start
    add_start(); add_start(); add_byte(8'h77); add_end();
    play(1);
    verify("R10 stale start", 0, 1);

    // R10: a fresh start after an end works
    add_start(); add_byte(8'h9C); add_end();
    exp_q.push_back(8'h9C);
    play(1);
    verify("R10 fresh start", 1, 0);

    // R4 R8: random frames with random idle gaps
    for (int f = 0; f < 20; f++) begin
      int nb = $urandom_range(0, 4);
      add_idle($urandom_range(0, 6));
      add_start();
      for (int i = 0; i < nb; i++) begin
        logic [7:0] b = 8'($urandom());
        add_byte(b);
        exp_q.push_back(b);
      end
      add_end();
      play(1);
      verify("R4 R8 random frame", 1, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule